// File: doc/BRIEF.md
# Event Performance Counter Unit

This block measures how often hardware events occur while a stretch of software runs. It holds six counters. Each counter has its own event-type register. That register steers one line of a shared event vector into the counter through a multiplexer. One of the event numbers is wired inside the block to fire on every clock, so a counter set to that number counts cycles. The other event numbers take their lines from the `ev_in` port, for example data-cache misses on line 3 and executed loads on line 6.

Software sets the unit up through a small write port with four registers. Setup and readout are indirect. A select register names the counter that an event-type write configures and that the `rd_count` port shows. A set-only enable register switches counters on. A control register starts or stops counting for all enabled counters. The same control write can also clear every counter, so one write can both zero the counters and start them. The write port has no handshake: a write is taken on every clock edge where `cfg_we` is high. `rd_count` always shows the selected counter as it stands.

Top module: `pmu_top`

## Requirements
- R1: After reset, every counter reads 0, no counter is enabled, counting is stopped, the select register holds 0 and every event type is 0.
- R2: A write to register 0 (select) with a value below 6 makes that counter the target of event-type writes and of `rd_count`. A select write with a value of 6 or more leaves the select register unchanged.
- R3: A write to register 1 (event type) stores bits [7:0] of the write data as the event number of the selected counter. Higher bits are ignored.
- R4: A write to register 2 (enable set) enables counter x for each bit x (x = 0 to 5) that is 1. Bits that are 0 leave the current enables unchanged.
- R5: A counter increases by exactly one at a clock edge where its chosen event fires, it is enabled and counting is running. In every other case it holds its value.
- R6: A write to register 3 (control) with bit 1 set zeroes all six counters at the edge that takes the write. The clear wins over any increment at that edge.
- R7: In a control write, bit 0 set starts counting and bit 0 clear stops it. The new state applies from the edge after the write, so writing 3 zeroes the counters and counting begins on the next cycle. While counting is stopped, the counters hold.
- R8: Event number 0x11 fires on every clock edge. Any other event number n below NUM_EV follows `ev_in[n]`: 0x03 is data-cache misses and 0x06 is executed loads. Event numbers of NUM_EV or more never fire.
- R9: A counter is CNT_W bits wide and wraps from its all-ones value to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe, taken every edge it is high |
| cfg_addr | input | 2 | Register number: 0 select, 1 event type, 2 enable set, 3 control |
| cfg_wdata | input | DATA_W (32) | Write data |
| ev_in | input | NUM_EV (32) | Hardware event lines, one per event number; line 0x11 is not used |
| rd_count | output | CNT_W (32) | Current value of the selected counter |

## Verification
A register write driven before edge E is visible at the next falling edge. After a select write, `rd_count` shows the new counter. After a clear, `rd_count` shows zero. Counting starts or stops at E+1, so the edge that takes a stop write still counts. The bench drives every input on falling edges and samples `rd_count` on falling edges only. The expected cycle count is the time between the falling edges that launch the start write and the stop write, divided by the clock period. That count includes the stop edge, as R7 requires. Event pulses last exactly one rising edge each, so each expected count is the number of pulses. The bench checks the clear-then-count rule one falling edge at a time.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

  // Register numbers on the write port.
  typedef enum logic [1:0] {
    REG_SEL   = 2'd0,
    REG_EVT   = 2'd1,
    REG_ENSET = 2'd2,
    REG_CTRL  = 2'd3
  } pmu_reg_e;

  localparam int EVT_W        = 8;      // width of an event number
  localparam int CYCLE_EVT    = 'h11;   // event fed by the clock itself
  localparam int CTRL_RUN_BIT = 0;
  localparam int CTRL_CLR_BIT = 1;

endpackage

// File: rtl/pmu_regs.sv
module pmu_regs
  import pmu_pkg::*;
#(
  parameter int NUM_CNT = 6,
  parameter int DATA_W  = 32,
  localparam int SEL_W  = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              cfg_we,
  input  logic [1:0]                        cfg_addr,
  input  logic [DATA_W-1:0]                 cfg_wdata,
  output logic [SEL_W-1:0]                  sel_q,
  output logic [NUM_CNT-1:0][EVT_W-1:0]     evt_q,
  output logic [NUM_CNT-1:0]                en_q,
  output logic                              run_q,
  output logic                              clr_all
);

  pmu_reg_e addr;
  logic     wr_sel, wr_evt, wr_en, wr_ctrl;
  logic     sel_ok;

  assign addr    = pmu_reg_e'(cfg_addr);
  assign wr_sel  = cfg_we && (addr == REG_SEL);
  assign wr_evt  = cfg_we && (addr == REG_EVT);
  assign wr_en   = cfg_we && (addr == REG_ENSET);
  assign wr_ctrl = cfg_we && (addr == REG_CTRL);
  assign sel_ok  = (cfg_wdata < DATA_W'(NUM_CNT));
  assign clr_all = wr_ctrl && cfg_wdata[CTRL_CLR_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (wr_sel && sel_ok) begin
      sel_q <= cfg_wdata[SEL_W-1:0];
    end
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_evt
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        evt_q[i] <= '0;
      end else if (wr_evt && (sel_q == SEL_W'(i))) begin
        evt_q[i] <= cfg_wdata[EVT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (wr_en) begin
      en_q <= en_q | cfg_wdata[NUM_CNT-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
    end else if (wr_ctrl) begin
      run_q <= cfg_wdata[CTRL_RUN_BIT];
    end
  end

endmodule

// File: rtl/pmu_evsel.sv
module pmu_evsel
  import pmu_pkg::*;
#(
  parameter int NUM_EV = 32
) (
  input  logic [NUM_EV-1:0] ev_vec,
  input  logic [EVT_W-1:0]  evt,
  output logic              fire
);

  // Numbers at or beyond NUM_EV match no line and never fire.
  always_comb begin
    fire = 1'b0;
    for (int n = 0; n < NUM_EV; n++) begin
      if (evt == EVT_W'(n)) fire = ev_vec[n];
    end
  end

endmodule

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt_q
);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt_q <= '0;
    end else if (inc) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/pmu_top.sv
module pmu_top
  import pmu_pkg::*;
#(
  parameter int NUM_CNT = 6,
  parameter int NUM_EV  = 32,
  parameter int CNT_W   = 32,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [NUM_EV-1:0] ev_in,
  output logic [CNT_W-1:0]  rd_count
);

  localparam int SEL_W = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1;

  logic [SEL_W-1:0]                sel_q;
  logic [NUM_CNT-1:0][EVT_W-1:0]   evt_q;
  logic [NUM_CNT-1:0]              en_q;
  logic                            run_q;
  logic                            clr_all;
  logic [NUM_EV-1:0]               ev_vec;
  logic [NUM_CNT-1:0]              fire;
  logic [NUM_CNT-1:0][CNT_W-1:0]   cnt_all;

  pmu_regs #(.NUM_CNT(NUM_CNT), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .sel_q     (sel_q),
    .evt_q     (evt_q),
    .en_q      (en_q),
    .run_q     (run_q),
    .clr_all   (clr_all)
  );

  // The cycle event line is driven internally, not by ev_in.
  if (CYCLE_EVT < NUM_EV) begin : g_cyc
    always_comb begin
      ev_vec            = ev_in;
      ev_vec[CYCLE_EVT] = 1'b1;
    end
  end else begin : g_nocyc
    assign ev_vec = ev_in;
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    pmu_evsel #(.NUM_EV(NUM_EV)) u_sel (
      .ev_vec (ev_vec),
      .evt    (evt_q[i]),
      .fire   (fire[i])
    );

    pmu_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr_all),
      .inc   (fire[i] && en_q[i] && run_q),
      .cnt_q (cnt_all[i])
    );
  end

  always_comb begin
    rd_count = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (sel_q == SEL_W'(i)) rd_count = cnt_all[i];
    end
  end

endmodule

// File: rtl/pmu_chk.sv
module pmu_chk
  import pmu_pkg::*;
#(
  parameter int NUM_CNT = 6,
  parameter int CNT_W   = 32,
  parameter int DATA_W  = 32,
  localparam int SEL_W  = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            cfg_we,
  input logic [1:0]                      cfg_addr,
  input logic [DATA_W-1:0]               cfg_wdata,
  input logic [SEL_W-1:0]                sel_q,
  input logic [NUM_CNT-1:0]              en_q,
  input logic                            run_q,
  input logic [NUM_CNT-1:0][CNT_W-1:0]   cnt_all
);

  logic ctrl_wr, clr_wr, bad_sel_wr;
  assign ctrl_wr    = cfg_we && (cfg_addr == 2'd3);
  assign clr_wr     = ctrl_wr && cfg_wdata[1];
  assign bad_sel_wr = cfg_we && (cfg_addr == 2'd0) && (cfg_wdata >= DATA_W'(NUM_CNT));

  assert_sel_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    32'(sel_q) < NUM_CNT);

  assert_bad_sel_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bad_sel_wr |=> $stable(sel_q));

  assert_en_set_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(en_q) & ~en_q) == '0));

  assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> (cnt_all == '0));

  assert_stop_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !cfg_wdata[0]) |=> !run_q);

  assert_stopped_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !clr_wr) |=> $stable(cnt_all));

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_step
    assert_step_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_wr |=> ((cnt_all[i] == $past(cnt_all[i])) ||
                   (cnt_all[i] == $past(cnt_all[i]) + CNT_W'(1))));
  end

endmodule

bind pmu_top pmu_chk #(
  .NUM_CNT (NUM_CNT),
  .CNT_W   (CNT_W),
  .DATA_W  (DATA_W)
) u_pmu_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_addr  (cfg_addr),
  .cfg_wdata (cfg_wdata),
  .sel_q     (sel_q),
  .en_q      (en_q),
  .run_q     (run_q),
  .cnt_all   (cnt_all)
);

// File: tb/tb_pmu_top.sv
`timescale 1ns/1ps
module tb_pmu_top;

  localparam int NUM_EV = 32;
  localparam int CNT_W  = 8;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic [1:0]        cfg_addr = 2'd0;
  logic [DATA_W-1:0] cfg_wdata = '0;
  logic [NUM_EV-1:0] ev_in = '0;
  logic [CNT_W-1:0]  rd_count;

  int total = 0;
  int bad   = 0;

  pmu_top #(.NUM_CNT(6), .NUM_EV(NUM_EV), .CNT_W(CNT_W), .DATA_W(DATA_W)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .ev_in     (ev_in),
    .rd_count  (rd_count)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // One write, taken at the rising edge after the launching falling edge.
  task automatic wr(input logic [1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic read_cnt(input int idx, input string req, input int exp);
    wr(2'd0, DATA_W'(idx));
    check(req, int'(rd_count), exp);
  endtask

  // Drive one event pattern for exactly one rising edge.
  task automatic pulse(input logic [NUM_EV-1:0] bits);
    @(negedge clk);
    ev_in = bits;
    @(negedge clk);
    ev_in = '0;
  endtask

  task automatic t_reset;
    for (int i = 0; i < 6; i++) read_cnt(i, "R1 counter zero after reset", 0);
    // Counter 0 has event 0 and no enable: a start write and a pulse on line 0 change nothing.
    wr(2'd3, 32'h1);
    pulse(32'h1);
    wr(2'd3, 32'h0);
    read_cnt(0, "R1 no enable after reset", 0);
  endtask

  time t_start, t_stop;

  task automatic t_count_events;
    wr(2'd0, 0); wr(2'd1, 32'h11);
    wr(2'd0, 1); wr(2'd1, 32'h03);
    wr(2'd0, 2); wr(2'd1, 32'h06);
    wr(2'd0, 3); wr(2'd1, 32'h128);   // R3: low byte 0x28 = 40, no such line
    wr(2'd0, 4); wr(2'd1, 32'hF03);   // R3: low byte 0x03
    wr(2'd0, 5); wr(2'd1, 32'h11);
    wr(2'd2, 32'h0F);
    wr(2'd2, 32'h10);                 // R4: zeros must not drop enables 0..3
    @(negedge clk);
    t_start = $time;
    wr(2'd3, 32'h3);
    for (int k = 0; k < 4; k++) pulse(32'h8);
    for (int k = 0; k < 3; k++) pulse(32'h40);
    pulse(32'h48);
    pulse(32'hFFFF_FF00);             // lines 8..31, none selected except the cycle line
    @(negedge clk);
    t_stop = $time;
    wr(2'd3, 32'h0);
    read_cnt(0, "R8 cycle event counts every edge incl. stop edge", int'((t_stop - t_start) / 10));
    read_cnt(1, "R8 miss event on line 3", 5);
    read_cnt(2, "R8 load event on line 6", 4);
    read_cnt(3, "R8 event beyond NUM_EV never fires", 0);
    read_cnt(4, "R3 upper write bits ignored", 5);
    read_cnt(5, "R5 disabled counter holds", 0);
    read_cnt(1, "R4 set-only enable kept counter 1", 5);
  endtask

  task automatic t_select;
    wr(2'd0, 2);
    wr(2'd0, 7);
    check("R2 select 7 ignored", int'(rd_count), 4);
    wr(2'd0, 32'h1000_0001);
    check("R2 large select ignored", int'(rd_count), 4);
    wr(2'd0, 1);
    check("R2 select switches readout", int'(rd_count), 5);
  endtask

  task automatic t_stop_hold;
    pulse(32'h48);
    pulse(32'h8);
    read_cnt(1, "R7 stopped counter holds", 5);
    read_cnt(0, "R7 stopped cycle counter holds", int'((t_stop - t_start) / 10));
  endtask

  task automatic t_clear_start;
    time t1, t2, t3, t4;
    wr(2'd3, 32'h2);
    read_cnt(0, "R6 clear only zeroes counter 0", 0);
    read_cnt(2, "R6 clear only zeroes counter 2", 0);
    @(negedge clk); t1 = $time;
    wr(2'd3, 32'h1);
    repeat (5) @(negedge clk);
    @(negedge clk); t2 = $time;
    wr(2'd3, 32'h0);
    read_cnt(0, "R7 start without clear counts", int'((t2 - t1) / 10));
    @(negedge clk); t3 = $time;
    wr(2'd3, 32'h1);
    repeat (3) @(negedge clk);
    @(negedge clk); t4 = $time;
    wr(2'd3, 32'h0);
    read_cnt(0, "R7 restart resumes from held value", int'((t2 - t1 + t4 - t3) / 10));
    // Clear while running, with the miss line high at the clear edge.
    wr(2'd0, 1);
    wr(2'd3, 32'h1);
    @(negedge clk);
    ev_in = 32'h8;
    wr(2'd3, 32'h3);
    check("R6 clear wins over event at same edge", int'(rd_count), 0);
    @(negedge clk);
    check("R7 counting begins the edge after clear", int'(rd_count), 1);
    ev_in = '0;
    wr(2'd3, 32'h0);
    check("R5 no event no increment", int'(rd_count), 1);
  endtask

  task automatic t_wrap;
    wr(2'd0, 0);
    wr(2'd3, 32'h3);
    repeat (255) @(negedge clk);
    check("R9 counter reaches all ones", int'(rd_count), 255);
    @(negedge clk);
    check("R9 counter wraps to zero", int'(rd_count), 0);
    @(negedge clk);
    check("R9 counting continues after wrap", int'(rd_count), 1);
    wr(2'd3, 32'h0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 readout zero after reset", int'(rd_count), 0);
    t_reset();
    t_count_events();
    t_select();
    t_stop_hold();
    t_clear_start();
    t_wrap();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule